// File: doc/BRIEF.md
# Up-Counting Timer with Match and PWM Output

This block is a general purpose timer for a peripheral subsystem. A 32-bit counter counts upward from a value that software writes. When the count passes the all-ones value the timer overflows. It then either reloads from a load register and keeps running, or stops with the count at zero. An optional power-of-two prescaler slows the count rate. A compare register can also produce a match event when the count reaches it.

Overflow and match events drive three outputs. An interrupt line is backed by a sticky status register that software clears by writing ones. A one-cycle wakeup pulse has its own enable mask. A pin output can pulse or toggle on events, so a reload period and a match point together make a PWM waveform. When it is not generating, the pin rests at a programmable idle level.

Software reaches the timer through a simple single-cycle 32-bit register port. Writes take effect at the clock edge and reads are combinational. The capture-related control fields are stored and read back, but they have no effect.

Top module: `uptimer_pwm`

## Requirements
- R1: After reset, or after a configuration write (offset 0x10) with bit 1 set, every register reads 0. Offset 0x00 always reads 0x21, and unmapped offsets such as 0x04 read 0. The configuration register keeps only the bits of mask 0x33D.
- R2: While control bit 0 (start) is 1, the counter (offset 0x28) rises by one per count step. A write to 0x28 sets the count directly, and the write wins over a count step in the same cycle.
- R3: When control bit 5 is 0, a count step occurs on every clock. When it is 1, a count step occurs once every 2^(P+1) clocks, where P is control bits 4:2.
- R4: A count step from 0xFFFFFFFF is an overflow. If control bit 1 (reload) is 1, the counter takes the load register value (offset 0x2C) and keeps running.
- R5: On an overflow with reload 0, the counter becomes 0 and control bit 0 clears.
- R6: A write of any value to offset 0x30 copies the load register into the counter. Offset 0x30 reads 0.
- R7: A match event occurs when control bit 6 is 1 and a count step gives the counter the value of the match register (offset 0x38).
- R8: Status (offset 0x18) has match in bit 0, overflow in bit 1 and capture in bit 2. A status bit is set by an event only if the same bit of the interrupt enable register (offset 0x1C) is 1. Writing a 1 clears a status bit, but an event in the same cycle wins. irq is high exactly while any status bit is 1.
- R9: wake is high for one cycle after each clock in which an event occurs whose bit is set in the wakeup mask (offset 0x20). The interrupt enables have no effect on wake.
- R10: Control bits 11:10 select the output events: 1 = overflow, 2 = overflow or match, 0 and 3 = none. When control bit 12 is 1, each output event inverts the pin. When it is 0, each output event inverts the pin for one cycle only.
- R11: While stopped, or while the event select is none, the pin returns to the level in control bit 7. While control bit 14 is 1 the pin is an input: pin_oe is 0 and pin_out is 0.
- R12: The control register (offset 0x24) keeps bits 14:0 as written, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt, high while any status bit is set |
| wake | output | 1 | One-cycle wakeup pulse |
| pin_out | output | 1 | Event / PWM pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Three corner cases are hard to reach from the ports: an overflow that happens in a prescaled run, an overflow and a match that land close together, and a status clear that meets a new event in the same cycle. The bench reaches them by preloading the counter a few counts below the all-ones value, with the match and load values placed near it. This way the timer wraps many times within a short run. A behavioural model steps alongside the design and predicts the pin, irq, wake and read data on every clock. Directed reads after each scenario pin down the stop-and-clear result and the masking of status.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 32;
    localparam int ADR_W = 8;
    localparam int PSC_W = 8;
    localparam int EVT_W = 3;
    localparam int CFG_W = 10;

    localparam logic [CFG_W-1:0] CFG_MASK  = 10'h33D;
    localparam logic [7:0]       ID_VALUE  = 8'h21;
    localparam int               SRST_BIT  = 1;

    localparam logic [ADR_W-1:0] OFF_ID   = 8'h00;
    localparam logic [ADR_W-1:0] OFF_CFG  = 8'h10;
    localparam logic [ADR_W-1:0] OFF_STS  = 8'h18;
    localparam logic [ADR_W-1:0] OFF_IEN  = 8'h1C;
    localparam logic [ADR_W-1:0] OFF_WEN  = 8'h20;
    localparam logic [ADR_W-1:0] OFF_CTL  = 8'h24;
    localparam logic [ADR_W-1:0] OFF_CNT  = 8'h28;
    localparam logic [ADR_W-1:0] OFF_LDV  = 8'h2C;
    localparam logic [ADR_W-1:0] OFF_TRG  = 8'h30;
    localparam logic [ADR_W-1:0] OFF_MAT  = 8'h38;

    localparam int EV_MAT = 0;
    localparam int EV_OVF = 1;
    localparam int EV_CAP = 2;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_OVF   = 2'd1,
        OUT_BOTH  = 2'd2,
        OUT_RSVD  = 2'd3
    } out_sel_e;

    typedef struct packed {
        logic       pin_in;
        logic       cap_sel;
        logic       toggle;
        out_sel_e   out_sel;
        logic [1:0] cap_edge;
        logic       idle_lvl;
        logic       cmp_en;
        logic       psc_en;
        logic [2:0] psc_val;
        logic       reload;
        logic       start;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] p);
        logic [PSC_W:0] span;
        span = (PSC_W+1)'(2) << p;
        return PSC_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PW = PSC_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       psc_en,
    input  logic [2:0] psc_val,
    output logic       tick
);
    logic [PW-1:0] psc;
    logic [PW-1:0] lim;
    logic          wrap;

    always_comb begin
        lim  = PW'(psc_limit(psc_val));
        wrap = (psc >= lim);
        tick = run && (!psc_en || wrap);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || !psc_en) begin
            psc <= '0;
        end else if (wrap) begin
            psc <= '0;
        end else begin
            psc <= psc + 1'b1;
        end
    end

    AST_PSC_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (psc == '0));  // R3

endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  out_sel_e out_sel,
    input  logic     toggle,
    input  logic     idle_lvl,
    input  logic     pin_in,
    input  logic     ovf_ev,
    input  logic     mat_ev,
    output logic     pin_out,
    output logic     pin_oe
);
    logic lvl;
    logic pls;
    logic active;
    logic fire;

    always_comb begin
        active = run && (out_sel == OUT_OVF || out_sel == OUT_BOTH);
        fire   = (out_sel == OUT_OVF  && ovf_ev) ||
                 (out_sel == OUT_BOTH && (ovf_ev || mat_ev));
        pin_oe  = !pin_in;
        pin_out = pin_oe && (lvl ^ pls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            pls <= 1'b0;
        end else if (!active) begin
            lvl <= idle_lvl;
            pls <= 1'b0;
        end else begin
            if (fire && toggle) begin
                lvl <= ~lvl;
            end
            pls <= fire && !toggle;
        end
    end

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |=> (lvl == $past(idle_lvl) && !pls));  // R11

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !fire) |=> (lvl == $past(lvl) && !pls));  // R10

endmodule

// File: rtl/uptimer_pwm.sv
module uptimer_pwm
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          irq,
    output logic          wake,
    output logic          pin_out,
    output logic          pin_oe
);
    ctl_t             ctl;
    logic [CW-1:0]    cnt, ldv, mat;
    logic [CFG_W-1:0] cfg;
    logic [EVT_W-1:0] sts, ien, wen;
    logic             wake_q;

    logic wr_cfg, wr_sts, wr_ien, wr_wen, wr_ctl, wr_cnt, wr_ldv, wr_trg, wr_mat;
    logic srst, rst_all, tick, ovf_ev, mat_ev;
    logic [CW-1:0]    nxt;
    logic [EVT_W-1:0] evt, clr;

    always_comb begin
        wr_cfg  = bus_wr && (bus_addr == OFF_CFG);
        wr_sts  = bus_wr && (bus_addr == OFF_STS);
        wr_ien  = bus_wr && (bus_addr == OFF_IEN);
        wr_wen  = bus_wr && (bus_addr == OFF_WEN);
        wr_ctl  = bus_wr && (bus_addr == OFF_CTL);
        wr_cnt  = bus_wr && (bus_addr == OFF_CNT);
        wr_ldv  = bus_wr && (bus_addr == OFF_LDV);
        wr_trg  = bus_wr && (bus_addr == OFF_TRG);
        wr_mat  = bus_wr && (bus_addr == OFF_MAT);
        srst    = wr_cfg && bus_wdata[SRST_BIT];
        rst_all = rst || srst;
    end

    tmr_prescale #(.PW(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst_all),
        .run     (ctl.start),
        .psc_en  (ctl.psc_en),
        .psc_val (ctl.psc_val),
        .tick    (tick)
    );

    always_comb begin
        ovf_ev = tick && (cnt == {CW{1'b1}});
        if (ovf_ev) begin
            nxt = ctl.reload ? ldv : '0;
        end else begin
            nxt = cnt + 1'b1;
        end
        mat_ev = tick && ctl.cmp_en && (nxt == mat);
        evt         = '0;
        evt[EV_MAT] = mat_ev;
        evt[EV_OVF] = ovf_ev;
        clr         = wr_sts ? bus_wdata[EVT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            ctl    <= '0;
            cnt    <= '0;
            ldv    <= '0;
            mat    <= '0;
            cfg    <= '0;
            sts    <= '0;
            ien    <= '0;
            wen    <= '0;
            wake_q <= 1'b0;
        end else begin
            if (wr_cfg) cfg <= bus_wdata[CFG_W-1:0] & CFG_MASK;
            if (wr_ien) ien <= bus_wdata[EVT_W-1:0];
            if (wr_wen) wen <= bus_wdata[EVT_W-1:0];
            if (wr_ldv) ldv <= bus_wdata;
            if (wr_mat) mat <= bus_wdata;
            if (wr_ctl) begin
                ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
            end else if (ovf_ev && !ctl.reload) begin
                ctl.start <= 1'b0;
            end
            if (wr_cnt) begin
                cnt <= bus_wdata;
            end else if (wr_trg) begin
                cnt <= ldv;
            end else if (tick) begin
                cnt <= nxt;
            end
            sts    <= (sts & ~clr) | (evt & ien);
            wake_q <= |(evt & wen);
        end
    end

    tmr_pin u_pin (
        .clk      (clk),
        .rst      (rst_all),
        .run      (ctl.start),
        .out_sel  (ctl.out_sel),
        .toggle   (ctl.toggle),
        .idle_lvl (ctl.idle_lvl),
        .pin_in   (ctl.pin_in),
        .ovf_ev   (ovf_ev),
        .mat_ev   (mat_ev),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    always_comb begin
        irq  = |sts;
        wake = wake_q;
        case (bus_addr)
            OFF_ID:  bus_rdata = CW'(ID_VALUE);
            OFF_CFG: bus_rdata = CW'(cfg);
            OFF_STS: bus_rdata = CW'(sts);
            OFF_IEN: bus_rdata = CW'(ien);
            OFF_WEN: bus_rdata = CW'(wen);
            OFF_CTL: bus_rdata = CW'(ctl);
            OFF_CNT: bus_rdata = cnt;
            OFF_LDV: bus_rdata = ldv;
            OFF_MAT: bus_rdata = mat;
            default: bus_rdata = '0;
        endcase
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst_all)
        (tick && !bus_wr && cnt != {CW{1'b1}}) |=> (cnt == $past(cnt) + 1'b1));  // R2

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst_all)
        (ovf_ev && ctl.reload && !bus_wr) |=> (cnt == $past(ldv) && ctl.start));  // R4

    AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (rst_all)
        (ovf_ev && !ctl.reload && !bus_wr) |=> (cnt == '0 && !ctl.start));  // R5

    AST_STS_MASKED: assert property (@(posedge clk) disable iff (rst_all)
        1'b1 |=> ((sts & ~$past(sts) & ~$past(ien)) == '0));  // R8

    AST_WAKE_ON_TICK: assert property (@(posedge clk) disable iff (rst_all)
        wake |-> $past(tick));  // R9

endmodule

// File: tb/sim_uptimer_pwm.sv
module sim_uptimer_pwm;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, wake, pin_out, pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    uptimer_pwm u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .wake(wake), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // behavioural reference state
    logic [14:0] m_ctl;
    logic [31:0] m_cnt, m_ldv, m_mat;
    logic [9:0]  m_cfg;
    logic [2:0]  m_sts, m_ien, m_wen;
    logic        m_wake, m_lvl, m_pls;
    int          m_psc;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return 32'h21;
            8'h10: return {22'h0, m_cfg};
            8'h18: return {29'h0, m_sts};
            8'h1C: return {29'h0, m_ien};
            8'h20: return {29'h0, m_wen};
            8'h24: return {17'h0, m_ctl};
            8'h28: return m_cnt;
            8'h2C: return m_ldv;
            8'h38: return m_mat;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_clear();
        m_ctl = '0; m_cnt = '0; m_ldv = '0; m_mat = '0; m_cfg = '0;
        m_sts = '0; m_ien = '0; m_wen = '0; m_wake = 0; m_lvl = 0; m_pls = 0;
        m_psc = 0;
    endtask

    task automatic m_step();
        bit start, rel, pre, ce, idle, tog, tick, ovf, mat, fire, act;
        int lim, sel;
        logic [31:0] nc;
        logic [2:0] ev, clr;
        start = m_ctl[0]; rel = m_ctl[1]; pre = m_ctl[5]; ce = m_ctl[6];
        idle = m_ctl[7]; sel = m_ctl[11:10]; tog = m_ctl[12];
        lim = (2 << m_ctl[4:2]) - 1;
        tick = 0;
        if (!start || !pre) begin
            tick = start;
            m_psc = 0;
        end else if (m_psc >= lim) begin
            tick = 1; m_psc = 0;
        end else begin
            m_psc = m_psc + 1;
        end
        ovf = tick && (m_cnt == 32'hFFFF_FFFF);
        nc  = ovf ? (rel ? m_ldv : 32'h0) : m_cnt + 1;
        mat = tick && ce && (nc == m_mat);
        ev  = {1'b0, ovf, mat};
        fire = (sel == 1 && ovf) || (sel == 2 && (ovf || mat));
        act  = start && (sel == 1 || sel == 2);
        if (!act) begin
            m_lvl = idle; m_pls = 0;
        end else begin
            if (fire && tog) m_lvl = !m_lvl;
            m_pls = fire && !tog;
        end
        clr = (bus_wr && bus_addr == 8'h18) ? bus_wdata[2:0] : 3'b0;
        m_sts  = (m_sts & ~clr) | (ev & m_ien);
        m_wake = |(ev & m_wen);
        if (tick) m_cnt = nc;
        if (ovf && !rel) m_ctl[0] = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                8'h10: m_cfg = bus_wdata[9:0] & 10'h33D;
                8'h1C: m_ien = bus_wdata[2:0];
                8'h20: m_wen = bus_wdata[2:0];
                8'h24: m_ctl = bus_wdata[14:0];
                8'h28: m_cnt = bus_wdata;
                8'h2C: m_ldv = bus_wdata;
                8'h30: m_cnt = m_ldv;
                8'h38: m_mat = bus_wdata;
                default: ;
            endcase
            if (bus_addr == 8'h10 && bus_wdata[1]) m_clear();
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_clear();
        end else begin
            m_step();
            #(PERIOD/4);
            if (!done) begin
                check("R8 irq", {31'h0, irq}, {31'h0, |m_sts});
                check("R9 wake", {31'h0, wake}, {31'h0, m_wake});
                check("R10 pin_out", {31'h0, pin_out}, {31'h0, !m_ctl[14] && (m_lvl ^ m_pls)});
                check("R11 pin_oe", {31'h0, pin_oe}, {31'h0, !m_ctl[14]});
                check("R2 rdata", bus_rdata, m_read(bus_addr));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 id", 8'h00, 32'h21);
        rd("R1 unmapped", 8'h04, 32'h0);
        rd("R1 ctl", 8'h24, 32'h0);
        rd("R1 cnt", 8'h28, 32'h0);
        rd("R1 sts", 8'h18, 32'h0);
        check("R11 reset pin_oe", {31'h0, pin_oe}, 32'h1);
        check("R8 reset irq", {31'h0, irq}, 32'h0);
        // R12 control layout read back, R1 config mask
        wr(8'h24, 32'hFFFF_7FFE);
        rd("R12 ctl readback", 8'h24, 32'h0000_7FFE);
        wr(8'h24, 32'h0);
        wr(8'h10, 32'hFFFF_FFFD);
        rd("R1 cfg mask", 8'h10, 32'h0000_033D);
        // R4 R7 R10 toggle, R9 wake, R8 status
        wr(8'h1C, 32'h7);
        wr(8'h20, 32'h7);
        wr(8'h2C, 32'hFFFF_FFE0);
        wr(8'h38, 32'hFFFF_FFF8);
        wr(8'h28, 32'hFFFF_FFF0);
        bus_addr = 8'h28;
        wr(8'h24, 32'h0000_1843);
        bus_addr = 8'h28;
        idle(120);
        wr(8'h1C, 32'h0);
        rd("R8 both set", 8'h18, 32'h3);
        wr(8'h18, 32'h1);
        rd("R8 w1c match", 8'h18, 32'h2);
        wr(8'h18, 32'h2);
        rd("R8 w1c ovf", 8'h18, 32'h0);
        check("R8 irq low", {31'h0, irq}, 32'h0);
        // pulse mode on overflow or match (R7 R10), then stop
        wr(8'h24, 32'h0000_0843);
        bus_addr = 8'h28;
        idle(80);
        wr(8'h24, 32'h0);
        // R3 R5 prescaled run to a stop, pulse on overflow
        wr(8'h28, 32'hFFFF_FFF0);
        wr(8'h24, 32'h0000_0429);
        bus_addr = 8'h28;
        idle(200);
        rd("R5 stopped ctl", 8'h24, 32'h0000_0428);
        rd("R5 cleared cnt", 8'h28, 32'h0);
        // R8 masking with wake only on overflow (R9)
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'h2);
        wr(8'h28, 32'hFFFF_FFFE);
        wr(8'h24, 32'h0000_0003);
        bus_addr = 8'h28;
        idle(20);
        rd("R8 masked sts", 8'h18, 32'h0);
        check("R8 masked irq", {31'h0, irq}, 32'h0);
        wr(8'h24, 32'h0);
        // R11 idle level and input direction
        wr(8'h24, 32'h0000_0081);
        idle(2);
        check("R11 idle high", {31'h0, pin_out}, 32'h1);
        wr(8'h24, 32'h0000_4081);
        idle(2);
        check("R11 input oe", {31'h0, pin_oe}, 32'h0);
        check("R11 input out", {31'h0, pin_out}, 32'h0);
        wr(8'h24, 32'h0000_0080);
        idle(2);
        check("R11 stopped idle", {31'h0, pin_out}, 32'h1);
        // R6 trigger reload, R2 direct write
        wr(8'h2C, 32'h0000_1234);
        wr(8'h30, 32'hDEAD_BEEF);
        rd("R6 trigger load", 8'h28, 32'h0000_1234);
        rd("R6 trigger reads 0", 8'h30, 32'h0);
        wr(8'h28, 32'h0000_0055);
        rd("R2 direct write", 8'h28, 32'h0000_0055);
        wr(8'h24, 32'h0000_0001);
        bus_addr = 8'h28;
        idle(10);
        wr(8'h24, 32'h0);
        // R1 soft reset
        wr(8'h10, 32'h0000_0002);
        rd("R1 soft cfg", 8'h10, 32'h0);
        rd("R1 soft ldv", 8'h2C, 32'h0);
        rd("R1 soft cnt", 8'h28, 32'h0);
        rd("R1 soft id", 8'h00, 32'h21);
        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD*150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule